// File: doc/BRIEF.md
# External Bus Cycle Sequencer with Idle-State Insertion

This block turns single access requests from an on-chip master into timed external bus cycles. Each request carries an area number, a direction, an address, write data and a burst flag. A full access has an address state with all strobes off, then a strobe state. Programmed wait states and waits requested on an external wait input can stretch the strobe state. A burst read starts with one full access and continues with short beats of one state each. The address steps by one on each beat, and the wait input has no effect during the beats.

The sequencer remembers the area and direction of the last completed access. It uses that record to decide whether to place one idle bus state in front of the next access. The idle state gives a slow device time to release the data bus before the next device drives it. There are two separately enabled cases: a read that follows a read to a different area, and a write that follows any read. During the idle state no strobe is active and the data bus is not driven. A one-cycle `done` pulse ends each access. `reqReady` is high whenever a new request can be taken, including the cycle in which `done` pulses.

Top module: `busSeq`

## Requirements
- R1: A full access with no waits drives the address with strobes off for one state, then asserts the read strobe (`busRd`) or the write strobe (`busWr`) for one state. `done` pulses in the third cycle after the accepting clock edge. Read and write strobes are never active together.
- R2: When `cfgRdIdleEn` is 1, a read that follows a read to a different area starts one state later, because one idle state comes first. A read to the same area, or any read while `cfgRdIdleEn` is 0, gets no idle state.
- R3: When `cfgWrIdleEn` is 1, a write that follows a read gets one idle state. In that state `busRd`, `busWr` and `busDataOe` are all 0. When `cfgWrIdleEn` is 0, the write gets no idle state, and `busDataOe` is 1 in the cycle after acceptance.
- R4: An access that follows a write never gets an idle state.
- R5: With `cfgWaitCnt` = W, a full access is longer by exactly W states.
- R6: `extWait` is sampled at the end of the last programmed wait state, or at the end of the strobe state when W = 0. Each state in which it is sampled high adds one more wait state.
- R7: A read with `reqBurst` = 1 is one full access followed by BURST_BEATS-1 beats of one state each. The address steps by 1 on each beat. Each word arrives on `rdata` with a `dataValid` pulse, and `done` coincides with the last word.
- R8: `extWait` high during burst beats adds no states.
- R9: `reqBurst` is ignored on writes: a write takes one full access and one write strobe.
- R10: Reset sets `reqReady` to 1 and sets `done`, `busRd`, `busWr` and `busDataOe` to 0. It also clears the access history, so the first access after reset gets no idle state.
- R11: A request that is held waiting is accepted in the same cycle that `done` pulses. Its idle decision uses the access that has just completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer can take a request |
| reqArea | input | AREA_W | Area number of the request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBurst | input | 1 | Burst read request |
| reqAddr | input | ADDR_W | Start address |
| reqWdata | input | DATA_W | Write data |
| cfgRdIdleEn | input | 1 | Enable idle state for read after read to another area |
| cfgWrIdleEn | input | 1 | Enable idle state for write after read |
| cfgWaitCnt | input | WAIT_W | Programmed wait states per full access |
| extWait | input | 1 | External wait request |
| busAddr | output | ADDR_W | External address (0 when not driven) |
| busRd | output | 1 | Read strobe |
| busWr | output | 1 | Write strobe |
| busDataOe | output | 1 | Data bus output enable |
| busDataOut | output | DATA_W | Write data toward the bus |
| busDataIn | input | DATA_W | Read data from the bus |
| rdata | output | DATA_W | Captured read word |
| dataValid | output | 1 | `rdata` holds a new word |
| done | output | 1 | Access completed |

## Verification
Two events can fall in the same cycle: the completion of one access and the acceptance of the next one. The idle decision for the new access must then use the history that was written on the very same edge. The bench provokes this by raising the next request while the current access is still running and holding it up until it is taken. It checks that `done` is high at acceptance, and that the new access's latency includes an idle state exactly when the access that just finished was a read of the matching kind. A second overlap puts `extWait` high across the burst beats while it is low at the sampling point. The beats must then keep their single-state timing.

// File: rtl/busSeqPkg.sv
package busSeqPkg;

  typedef enum logic [2:0] {
    S_READY,
    S_IDLE,
    S_T1,
    S_T2,
    S_TW,
    S_BURST
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic addrInc;
    logic driveAddr;
    logic rdStb;
    logic wrStb;
    logic dataOe;
    logic capture;
  } seqStrobe_t;

endpackage

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busSeqPkg::*;
#(
  parameter int AREA_W      = 3,
  parameter int WAIT_W      = 3,
  parameter int BURST_BEATS = 4   // must be 2 or more
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [AREA_W-1:0] reqArea,
  input  logic              reqWrite,
  input  logic              reqBurst,
  input  logic              cfgRdIdleEn,
  input  logic              cfgWrIdleEn,
  input  logic [WAIT_W-1:0] cfgWaitCnt,
  input  logic              extWait,
  output logic              reqReady,
  output logic              done,
  output seqStrobe_t        stb
);

  localparam int BEAT_W = $clog2(BURST_BEATS) + 1;

  seqState_t         state;
  logic [WAIT_W-1:0] waitLeft;
  logic [BEAT_W-1:0] beatLeft;
  logic [AREA_W-1:0] curArea, lastArea;
  logic              curWrite, curBurst;
  logic              lastValid, lastWrite;
  logic              doneQ;

  logic accept, needIdle, fullLast, beatLast, strobing;

  always_comb begin
    accept   = (state == S_READY) && reqValid;
    needIdle = lastValid && !lastWrite &&
               ((!reqWrite && cfgRdIdleEn && (reqArea != lastArea)) ||
                ( reqWrite && cfgWrIdleEn));
    fullLast = ((state == S_T2) && (cfgWaitCnt == '0) && !extWait) ||
               ((state == S_TW) && (waitLeft == '0) && !extWait);
    beatLast = (state == S_BURST) && (beatLeft == BEAT_W'(1));
    strobing = (state == S_T2) || (state == S_TW) || (state == S_BURST);

    stb           = '0;
    stb.loadReq   = accept;
    stb.driveAddr = (state == S_T1) || strobing;
    stb.rdStb     = strobing && !curWrite;
    stb.wrStb     = strobing && curWrite;
    stb.dataOe    = curWrite && ((state == S_T1) || (state == S_T2) || (state == S_TW));
    stb.capture   = !curWrite && (fullLast || (state == S_BURST));
    stb.addrInc   = (fullLast && curBurst) || ((state == S_BURST) && !beatLast);
  end

  assign reqReady = (state == S_READY);
  assign done     = doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_READY;
      waitLeft  <= '0;
      beatLeft  <= '0;
      curArea   <= '0;
      curWrite  <= 1'b0;
      curBurst  <= 1'b0;
      lastValid <= 1'b0;
      lastWrite <= 1'b0;
      lastArea  <= '0;
      doneQ     <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        S_READY: begin
          if (accept) begin
            curArea  <= reqArea;
            curWrite <= reqWrite;
            curBurst <= reqBurst && !reqWrite;
            state    <= needIdle ? S_IDLE : S_T1;
          end
        end
        S_IDLE: state <= S_T1;
        S_T1:   state <= S_T2;
        S_T2: begin
          if (cfgWaitCnt != '0) begin
            waitLeft <= cfgWaitCnt - WAIT_W'(1);
            state    <= S_TW;
          end else if (extWait) begin
            waitLeft <= '0;
            state    <= S_TW;
          end
        end
        S_TW: begin
          if (waitLeft != '0) waitLeft <= waitLeft - WAIT_W'(1);
        end
        S_BURST: begin
          if (!beatLast) beatLeft <= beatLeft - BEAT_W'(1);
        end
        default: state <= S_READY;
      endcase

      if (fullLast && curBurst) begin
        state    <= S_BURST;
        beatLeft <= BEAT_W'(BURST_BEATS - 1);
      end else if ((fullLast && !curBurst) || beatLast) begin
        state     <= S_READY;
        doneQ     <= 1'b1;
        lastValid <= 1'b1;
        lastWrite <= curWrite;
        lastArea  <= curArea;
      end
    end
  end

  // an idle state lasts exactly one cycle and leads into the address state
  assert_idle_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |=> (state == S_T1));

  // nothing following a write is delayed by an idle state
  assert_after_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accept && lastValid && lastWrite) |=> (state == S_T1));

  // an empty history never yields an idle state
  assert_first_access_R10: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !lastValid) |=> (state == S_T1));

  // the pin keeps the cycle stretched once programmed waits are used up
  assert_pin_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_TW) && (waitLeft == '0) && extWait) |=> (state == S_TW));

  // beats advance every cycle whatever the wait pin does
  assert_beat_nowait_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_BURST) && (beatLeft > BEAT_W'(1))) |=>
      ((state == S_BURST) && (beatLeft == $past(beatLeft) - BEAT_W'(1))));

  // done is a single-cycle pulse
  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/busSeqData.sv
module busSeqData
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRd,
  output logic              busWr,
  output logic              busDataOe,
  output logic [DATA_W-1:0] busDataOut,
  output logic [DATA_W-1:0] rdata,
  output logic              dataValid
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;
  logic              dataValidQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ      <= '0;
      wdataQ     <= '0;
      rdataQ     <= '0;
      dataValidQ <= 1'b0;
    end else begin
      if (stb.loadReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end else if (stb.addrInc) begin
        addrQ <= addrQ + ADDR_W'(1);
      end
      if (stb.capture) rdataQ <= busDataIn;
      dataValidQ <= stb.capture;
    end
  end

  assign busAddr    = stb.driveAddr ? addrQ : '0;
  assign busRd      = stb.rdStb;
  assign busWr      = stb.wrStb;
  assign busDataOe  = stb.dataOe;
  assign busDataOut = stb.dataOe ? wdataQ : '0;
  assign rdata      = rdataQ;
  assign dataValid  = dataValidQ;

  // each burst step moves the external address by one word
  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.addrInc |=> (busAddr == $past(busAddr) + ADDR_W'(1)));

  // the bus is never driven while a read strobe is active
  assert_oe_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(busDataOe && busRd));

  // the two strobes never overlap
  assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));

endmodule

// File: rtl/busSeq.sv
module busSeq
  import busSeqPkg::*;
#(
  parameter int AREA_W      = 3,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int WAIT_W      = 3,
  parameter int BURST_BEATS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [AREA_W-1:0] reqArea,
  input  logic              reqWrite,
  input  logic              reqBurst,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              cfgRdIdleEn,
  input  logic              cfgWrIdleEn,
  input  logic [WAIT_W-1:0] cfgWaitCnt,
  input  logic              extWait,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRd,
  output logic              busWr,
  output logic              busDataOe,
  output logic [DATA_W-1:0] busDataOut,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [DATA_W-1:0] rdata,
  output logic              dataValid,
  output logic              done
);

  seqStrobe_t stb;

  busSeqCtrl #(
    .AREA_W(AREA_W), .WAIT_W(WAIT_W), .BURST_BEATS(BURST_BEATS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqArea(reqArea),
    .reqWrite(reqWrite), .reqBurst(reqBurst), .cfgRdIdleEn(cfgRdIdleEn),
    .cfgWrIdleEn(cfgWrIdleEn), .cfgWaitCnt(cfgWaitCnt), .extWait(extWait),
    .reqReady(reqReady), .done(done), .stb(stb)
  );

  busSeqData #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) data_i (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .busDataIn(busDataIn), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busDataOe(busDataOe), .busDataOut(busDataOut), .rdata(rdata),
    .dataValid(dataValid)
  );

endmodule

// File: tb/busSeq_tb_top.sv
module busSeq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AREA_W = 3;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int WAIT_W = 3;
  localparam int BEATS  = 4;
  localparam logic [DATA_W-1:0] MASK = 16'h5A3C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqBurst = 1'b0;
  logic [AREA_W-1:0] reqArea = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic cfgRdIdleEn = 1'b1, cfgWrIdleEn = 1'b1;
  logic [WAIT_W-1:0] cfgWaitCnt = '0;
  logic extWait = 1'b0;
  logic reqReady, busRd, busWr, busDataOe, dataValid, done;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busDataOut, rdata, busDataIn;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign busDataIn = busRd ? (busAddr ^ MASK) : '0;

  busSeq #(.AREA_W(AREA_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
           .WAIT_W(WAIT_W), .BURST_BEATS(BEATS)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqArea(reqArea), .reqWrite(reqWrite), .reqBurst(reqBurst),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .cfgRdIdleEn(cfgRdIdleEn),
    .cfgWrIdleEn(cfgWrIdleEn), .cfgWaitCnt(cfgWaitCnt), .extWait(extWait),
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .busDataOe(busDataOe),
    .busDataOut(busDataOut), .busDataIn(busDataIn), .rdata(rdata),
    .dataValid(dataValid), .done(done)
  );

  typedef struct {
    int    area;
    bit    wr;
    bit    burst;
    int    addr;
    int    wdata;
    bit    idle;
    int    lat;
    int    accCyc;
    string tag;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0, cycN = 0, beatIdx = 0;
  int curAcc = 0, curK = 0, curB0 = 0, curB1 = -1;
  bit mLastValid = 0, mLastWr = 0;
  int mLastArea = 0;
  int wrAddrSeen = 0, wrDataSeen = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cycN <= cycN + 1;

  // external wait pin model
  always @(negedge clk) begin
    int k;
    k = cycN - curAcc + 1;
    extWait = (k >= 1 && k <= curK) || (k >= curB0 && k <= curB1);
  end

  // scoreboard monitor
  always @(negedge clk) begin
    int k;
    if (rstN && q.size() > 0) begin
      k = cycN - q[0].accCyc + 1;
      if (k == 1 && q[0].idle)
        check(!busRd && !busWr && !busDataOe, "R3", "strobes in idle state",
              int'({busRd, busWr, busDataOe}), 0);
      if (k == 1 && q[0].wr && !q[0].idle)
        check(busDataOe == 1'b1, "R3", "data driven right after accept",
              int'(busDataOe), 1);
      if (busWr) begin
        wrAddrSeen = int'(busAddr);
        wrDataSeen = int'(busDataOut);
      end
      if (dataValid) begin
        check(int'(rdata) == ((q[0].addr + beatIdx) ^ int'(MASK)), q[0].tag,
              "read word", int'(rdata), (q[0].addr + beatIdx) ^ int'(MASK));
        beatIdx++;
      end
      if (done) begin
        check(cycN == q[0].accCyc + q[0].lat - 1, q[0].tag, "done latency",
              cycN - q[0].accCyc + 1, q[0].lat);
        if (q[0].wr) begin
          check(wrAddrSeen == q[0].addr, q[0].tag, "write address", wrAddrSeen, q[0].addr);
          check(wrDataSeen == q[0].wdata, q[0].tag, "write data", wrDataSeen, q[0].wdata);
        end else begin
          check(beatIdx == (q[0].burst ? BEATS : 1), q[0].tag, "word count",
                beatIdx, q[0].burst ? BEATS : 1);
        end
        beatIdx = 0;
        void'(q.pop_front());
      end
    end
  end

  // driver: computes the expected timing from the requirements, then issues
  task automatic doAccess(int area, bit wr, bit burst, int addr, int wdata,
                          int k, bit win, bit b2b, string tag);
    item_t it;
    int base, l, extra;
    bit isB;
    it.idle = mLastValid && !mLastWr &&
              ((!wr && cfgRdIdleEn && area != mLastArea) || (wr && cfgWrIdleEn));
    isB   = burst && !wr;
    base  = 1 + int'(it.idle);
    l     = base + 1 + int'(cfgWaitCnt);
    extra = (k >= l) ? (k - l + 1) : 0;
    it.lat   = l + extra + 1 + (isB ? BEATS - 1 : 0);
    it.area  = area; it.wr = wr; it.burst = isB;
    it.addr  = addr; it.wdata = wdata; it.tag = tag;
    @(negedge clk);
    reqArea  = AREA_W'(area);
    reqWrite = wr;
    reqBurst = burst;
    reqAddr  = ADDR_W'(addr);
    reqWdata = DATA_W'(wdata);
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    if (b2b) check(done == 1'b1, "R11", "accepted in done cycle", int'(done), 1);
    it.accCyc = cycN + 1;
    curAcc = it.accCyc;
    curK   = k;
    curB0  = win ? (l + extra + 1) : 0;
    curB1  = win ? (l + extra + BEATS - 1) : -1;
    q.push_back(it);
    mLastValid = 1; mLastWr = wr; mLastArea = area;
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cycN > 20000) begin
      total++; bad++;
      $display("FAIL watchdog all requirements actual=%0d expected=%0d", cycN, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: state held by reset
    check(reqReady == 1'b1, "R10", "ready in reset", int'(reqReady), 1);
    check({done, busRd, busWr, busDataOe} == 4'b0, "R10", "outputs in reset",
          int'({done, busRd, busWr, busDataOe}), 0);
    rstN = 1'b1;
    @(negedge clk);

    doAccess(1, 0, 0, 'h0100, 0, 0, 0, 0, "R10");      // first, no idle
    doAccess(1, 0, 0, 'h0110, 0, 0, 0, 0, "R2");       // same area
    doAccess(2, 0, 0, 'h0200, 0, 0, 0, 0, "R2");       // other area: idle
    doAccess(2, 1, 0, 'h0204, 'hBEEF, 0, 0, 0, "R3");  // write after read: idle
    doAccess(3, 0, 0, 'h0300, 0, 0, 0, 0, "R4");       // after write: no idle
    drain();
    cfgRdIdleEn = 1'b0;
    doAccess(4, 0, 0, 'h0400, 0, 0, 0, 0, "R2");       // disabled
    drain();
    cfgWrIdleEn = 1'b0;
    doAccess(4, 1, 0, 'h0408, 'h1234, 0, 0, 0, "R3");  // disabled
    drain();
    cfgWaitCnt = 3'd2;
    doAccess(5, 0, 0, 'h0500, 0, 0, 0, 0, "R5");
    drain();
    cfgWaitCnt = 3'd1;
    doAccess(5, 0, 0, 'h0510, 0, 6, 0, 0, "R6");       // pin stretches
    drain();
    cfgWaitCnt = 3'd0;
    cfgRdIdleEn = 1'b1;
    doAccess(6, 0, 1, 'h0600, 0, 0, 1, 0, "R7 R8");    // burst, pin high on beats
    doAccess(6, 0, 1, 'h0620, 0, 3, 1, 0, "R6 R7");    // pin wait on first access
    doAccess(6, 1, 1, 'h0630, 'hCAFE, 0, 0, 0, "R9");  // burst flag on write
    drain();
    cfgWrIdleEn = 1'b1;
    doAccess(1, 0, 0, 'h0700, 0, 0, 0, 0, "R11");
    doAccess(2, 0, 0, 'h0710, 0, 0, 0, 1, "R11");
    doAccess(2, 1, 0, 'h0714, 'hA5A5, 0, 0, 1, "R11");
    doAccess(3, 0, 0, 'h0720, 0, 0, 0, 1, "R11");
    doAccess(4, 0, 0, 'h0724, 0, 0, 0, 1, "R11");
    drain();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mLastValid = 0;
    doAccess(7, 0, 0, 'h0800, 0, 0, 0, 0, "R10");      // history cleared
    drain();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule